// File: doc/BRIEF.md
# Dual External Bus Transfer Steering

This block accepts one transfer request at a time from the internal side and places it on one of two external buses: a primary bus or a calibration bus. The request selects the bus. For that bus the block produces the two-bit transfer-size code, the four byte-lane enables, a one-cycle active-low transfer start and an active-low chip select for the addressed bank. It also drives the enable for that bus's data drivers. The other bus stays negated throughout. During a calibration cycle the primary bus still shows the address and the direction, but it never starts a transfer.

Requests that come from an external master take their size from the external size pins. A configuration override can replace those pins with a configuration size field. Requests this block masters itself always use their own size. A size code that is invalid, a byte run that would leave the 32-bit word, or an external-master request aimed at the calibration bus is refused. The refusal is a one-cycle error pulse, and no transfer starts.

Top module: `xbus_steer`

## Requirements
- R1: On a non-burst transfer the size code is 01 for 1 byte, 10 for 2 bytes and 00 for 4 bytes. Byte-lane enable bit i is set when byte offset i lies in the run that starts at offset req_addr[1:0] and has that many bytes.
- R2: On a burst transfer the output size code is 00 and all four byte lanes are enabled, whatever size is requested.
- R3: Size code 11, or a run where offset plus byte count exceeds 4, raises xfer_err for exactly the cycle after the request. No transfer start and no chip select follow.
- R4: For an external-master request (req_ext=1) the size comes from cfg_size when cfg_size_en=1 and from ext_size_pins when cfg_size_en=0. For a request the block masters itself (req_ext=0) the size comes from req_size, whatever cfg_size_en and cfg_size hold.
- R5: An accepted request drives the selected bus's transfer start low for exactly the one cycle after the request is sampled.
- R6: The selected bus's chip select bit for req_bank goes low in that same cycle. It stays low until the cycle after xfer_ack is sampled high. All other chip select bits stay high.
- R7: During a calibration cycle the primary bus keeps transfer start high, all chip selects high, byte lanes at 0, size code at 00 and its data enable at 0. Its address and write bit equal those on the calibration bus.
- R8: During a primary cycle the calibration bus is fully negated: address 0, write bit 0, size code 00, lanes 0, transfer start high, chip selects high and data enable 0.
- R9: A data enable is 1 only for a write, only on the selected bus, and only while that bus's chip select is active.
- R10: An external-master request with req_cal=1 is refused with xfer_err and starts no transfer on either bus.
- R11: A request presented while xfer_busy is 1 is ignored. The running transfer's address, bank and outputs are unchanged.
- R12: While reset is held and after it is released, both buses are negated and xfer_busy and xfer_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_addr | input | AW | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code for self-mastered requests |
| req_burst | input | 1 | Burst transfer |
| req_bank | input | BANK_W | Target bank |
| req_cal | input | 1 | 1 = calibration bus, 0 = primary bus |
| req_ext | input | 1 | Request originates from an external master |
| ext_size_pins | input | 2 | Size code seen on the external size pins |
| cfg_size_en | input | 1 | Override external-master size with cfg_size |
| cfg_size | input | 2 | Override size code |
| xfer_ack | input | 1 | Transfer acknowledge, ends the cycle |
| pri_addr | output | AW | Primary address |
| pri_wr | output | 1 | Primary write bit |
| pri_tsize | output | 2 | Primary size code |
| pri_be | output | 4 | Primary byte-lane enables |
| pri_ts_n | output | 1 | Primary transfer start, active low |
| pri_cs_n | output | NBANK | Primary chip selects, active low |
| pri_data_oe | output | 1 | Primary data driver enable |
| cal_addr | output | AW | Calibration address |
| cal_wr | output | 1 | Calibration write bit |
| cal_tsize | output | 2 | Calibration size code |
| cal_be | output | 4 | Calibration byte-lane enables |
| cal_ts_n | output | 1 | Calibration transfer start, active low |
| cal_cs_n | output | NBANK | Calibration chip selects, active low |
| cal_data_oe | output | 1 | Calibration data driver enable |
| xfer_busy | output | 1 | A transfer is in progress |
| xfer_err | output | 1 | One-cycle pulse: request refused |

## Verification
The assertions assume that xfer_ack arrives only while a transfer is in progress, and that req_bank stays below NBANK. They also assume the requester tolerates a refused request without retrying in the same cycle. The stimulus raises xfer_ack only after the chip select has been seen active, and drops it on the following cycle. It uses banks 0 through 3 only. It presents at most one request per transaction, apart from one deliberate extra request while busy. That extra request is the stimulus for R11, and its effect is judged only at the outputs.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_BAD  = 2'b11
    } xsize_e;

endpackage

// File: rtl/xbus_size_pick.sv
module xbus_size_pick (
    input  logic       ext_i,
    input  logic       ovr_en_i,
    input  logic [1:0] ovr_size_i,
    input  logic [1:0] pin_size_i,
    input  logic [1:0] own_size_i,
    output logic [1:0] size_o
);
    // The override applies to external-master cycles only.
    always_comb begin
        if (!ext_i)
            size_o = own_size_i;
        else if (ovr_en_i)
            size_o = ovr_size_i;
        else
            size_o = pin_size_i;
    end
endmodule

// File: rtl/xbus_lane_decode.sv
module xbus_lane_decode
    import xbus_pkg::*;
(
    input  logic             burst_i,
    input  logic [1:0]       code_i,
    input  logic [1:0]       offs_i,
    output logic [1:0]       tsize_o,
    output logic [LANES-1:0] be_o,
    output logic             bad_o
);
    logic [2:0] nbytes;
    logic [3:0] run_end;

    always_comb begin
        case (xsize_e'(code_i))
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
        run_end = {2'b00, offs_i} + {1'b0, nbytes};
        tsize_o = burst_i ? SZ_WORD : code_i;
        bad_o   = !burst_i &&
                  ((xsize_e'(code_i) == SZ_BAD) || (run_end > 4'(LANES)));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_o[i] = burst_i ||
                         ((4'(i) >= {2'b00, offs_i}) && (4'(i) < run_end));
    end
endmodule

// File: rtl/xbus_steer.sv
module xbus_steer
    import xbus_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NBANK  = 4,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_burst,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_cal,
    input  logic              req_ext,
    input  logic [1:0]        ext_size_pins,
    input  logic              cfg_size_en,
    input  logic [1:0]        cfg_size,
    input  logic              xfer_ack,
    output logic [AW-1:0]     pri_addr,
    output logic              pri_wr,
    output logic [1:0]        pri_tsize,
    output logic [LANES-1:0]  pri_be,
    output logic              pri_ts_n,
    output logic [NBANK-1:0]  pri_cs_n,
    output logic              pri_data_oe,
    output logic [AW-1:0]     cal_addr,
    output logic              cal_wr,
    output logic [1:0]        cal_tsize,
    output logic [LANES-1:0]  cal_be,
    output logic              cal_ts_n,
    output logic [NBANK-1:0]  cal_cs_n,
    output logic              cal_data_oe,
    output logic              xfer_busy,
    output logic              xfer_err
);

    typedef struct packed {
        logic              busy;
        logic              cal;
        logic              first;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [AW-1:0]     addr;
        logic [1:0]        tsize;
        logic [LANES-1:0]  be;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]       eff_size;
    logic [1:0]       dec_tsize;
    logic [LANES-1:0] dec_be;
    logic             dec_bad;

    xbus_size_pick u_pick (
        .ext_i      (req_ext),
        .ovr_en_i   (cfg_size_en),
        .ovr_size_i (cfg_size),
        .pin_size_i (ext_size_pins),
        .own_size_i (req_size),
        .size_o     (eff_size)
    );

    xbus_lane_decode u_dec (
        .burst_i (req_burst),
        .code_i  (eff_size),
        .offs_i  (req_addr[1:0]),
        .tsize_o (dec_tsize),
        .be_o    (dec_be),
        .bad_o   (dec_bad)
    );

    always_comb begin
        st_d       = st_q;
        st_d.first = 1'b0;
        st_d.err   = 1'b0;
        if (st_q.busy) begin
            if (xfer_ack)
                st_d = '0;
        end else if (req_valid) begin
            if (dec_bad || (req_ext && req_cal)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy  = 1'b1;
                st_d.cal   = req_cal;
                st_d.first = 1'b1;
                st_d.wr    = req_write;
                st_d.bank  = req_bank;
                st_d.addr  = req_addr;
                st_d.tsize = dec_tsize;
                st_d.be    = dec_be;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic pri_act, cal_act;
    assign pri_act = st_q.busy && !st_q.cal;
    assign cal_act = st_q.busy &&  st_q.cal;

    // The primary side mirrors address and direction in both kinds of cycle.
    assign pri_addr    = st_q.busy ? st_q.addr : '0;
    assign pri_wr      = st_q.busy && st_q.wr;
    assign pri_tsize   = pri_act ? st_q.tsize : 2'b00;
    assign pri_be      = pri_act ? st_q.be : '0;
    assign pri_ts_n    = !(pri_act && st_q.first);
    assign pri_data_oe = pri_act && st_q.wr;

    assign cal_addr    = cal_act ? st_q.addr : '0;
    assign cal_wr      = cal_act && st_q.wr;
    assign cal_tsize   = cal_act ? st_q.tsize : 2'b00;
    assign cal_be      = cal_act ? st_q.be : '0;
    assign cal_ts_n    = !(cal_act && st_q.first);
    assign cal_data_oe = cal_act && st_q.wr;

    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign pri_cs_n[b] = !(pri_act && (st_q.bank == BANK_W'(b)));
        assign cal_cs_n[b] = !(cal_act && (st_q.bank == BANK_W'(b)));
    end

    assign xfer_busy = st_q.busy;
    assign xfer_err  = st_q.err;

    // R5
    pri_ts_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_ts_n |=> pri_ts_n);
    // R5
    cal_ts_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_ts_n |=> cal_ts_n);
    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pri_cs_n) && $onehot0(~cal_cs_n));
    // R6
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pri_cs_n != '1 || cal_cs_n != '1) && !xfer_ack) |=>
            ($stable(pri_cs_n) && $stable(cal_cs_n)));
    // R7
    cal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_cs_n != '1) |-> (pri_cs_n == '1 && pri_ts_n && !pri_data_oe &&
                              pri_addr == cal_addr && pri_wr == cal_wr));
    // R8
    pri_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_cs_n != '1) |-> (cal_cs_n == '1 && cal_ts_n && !cal_data_oe &&
                              cal_addr == '0 && cal_be == '0));
    // R9
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_data_oe |-> pri_cs_n != '1) and (cal_data_oe |-> cal_cs_n != '1));
    // R3
    err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> (pri_ts_n && cal_ts_n && !xfer_busy));
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !xfer_ack) |=> ($stable(pri_addr) && xfer_busy));

endmodule

// File: tb/xbus_steer_bench.sv
module xbus_steer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic        req_burst = 1'b0;
    logic [1:0]  req_bank = '0;
    logic        req_cal = 1'b0;
    logic        req_ext = 1'b0;
    logic [1:0]  ext_size_pins = '0;
    logic        cfg_size_en = 1'b0;
    logic [1:0]  cfg_size = '0;
    logic        xfer_ack = 1'b0;

    logic [31:0] pri_addr, cal_addr;
    logic        pri_wr, cal_wr, pri_ts_n, cal_ts_n, pri_data_oe, cal_data_oe;
    logic [1:0]  pri_tsize, cal_tsize;
    logic [3:0]  pri_be, cal_be, pri_cs_n, cal_cs_n;
    logic        xfer_busy, xfer_err;

    always #2 clk = ~clk;

    xbus_steer u_xbus_steer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_burst(req_burst),
        .req_bank(req_bank), .req_cal(req_cal), .req_ext(req_ext),
        .ext_size_pins(ext_size_pins), .cfg_size_en(cfg_size_en),
        .cfg_size(cfg_size), .xfer_ack(xfer_ack),
        .pri_addr(pri_addr), .pri_wr(pri_wr), .pri_tsize(pri_tsize),
        .pri_be(pri_be), .pri_ts_n(pri_ts_n), .pri_cs_n(pri_cs_n),
        .pri_data_oe(pri_data_oe), .cal_addr(cal_addr), .cal_wr(cal_wr),
        .cal_tsize(cal_tsize), .cal_be(cal_be), .cal_ts_n(cal_ts_n),
        .cal_cs_n(cal_cs_n), .cal_data_oe(cal_data_oe),
        .xfer_busy(xfer_busy), .xfer_err(xfer_err)
    );

    typedef struct {
        int          stamp;
        string       req;
        logic [91:0] v;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [91:0] pack(bit busy, bit err, bit cal, bit first,
                                         bit wr, int bank, logic [31:0] addr,
                                         logic [1:0] ts, logic [3:0] be);
        bit pa = busy && !cal;
        bit ca = busy && cal;
        logic [3:0] pcs = 4'hF;
        logic [3:0] ccs = 4'hF;
        if (pa) pcs[bank] = 1'b0;
        if (ca) ccs[bank] = 1'b0;
        return {busy, err, busy ? addr : 32'h0, busy && wr,
                pa ? ts : 2'b00, pa ? be : 4'h0, !(pa && first), pcs, pa && wr,
                ca ? addr : 32'h0, ca && wr, ca ? ts : 2'b00, ca ? be : 4'h0,
                !(ca && first), ccs, ca && wr};
    endfunction

    function automatic logic [91:0] idle_v();
        return pack(0, 0, 0, 0, 0, 0, 32'h0, 2'b00, 4'h0);
    endfunction

    task automatic push(int stamp, string req, logic [91:0] v);
        item_t it;
        it.stamp = stamp;
        it.req = req;
        it.v = v;
        q.push_back(it);
    endtask

    // Monitor: compares outputs against the queued items once per cycle.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].stamp <= cyc) begin
            logic [91:0] act;
            act = {xfer_busy, xfer_err, pri_addr, pri_wr, pri_tsize, pri_be,
                   pri_ts_n, pri_cs_n, pri_data_oe, cal_addr, cal_wr, cal_tsize,
                   cal_be, cal_ts_n, cal_cs_n, cal_data_oe};
            n_chk++;
            if (q[0].stamp != cyc || act !== q[0].v) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual %h expected %h",
                         q[0].req, cyc, act, q[0].v);
            end
            void'(q.pop_front());
        end
    end

    // Driver: presents one request and queues the expected output per cycle.
    task automatic xfer(logic [31:0] addr, bit wr, logic [1:0] size, bit burst,
                        int bank, bit cal, bit ext, logic [1:0] pins, bit cen,
                        logic [1:0] csz, int d, bit spur, string req);
        logic [1:0] code, ts;
        logic [3:0] be;
        int n, lo, s0;
        bit bad;
        code = ext ? (cen ? csz : pins) : size;
        n  = (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 4;
        lo = int'(addr[1:0]);
        be = 4'h0;
        for (int i = 0; i < 4; i++)
            if (burst || (i >= lo && i < lo + n)) be[i] = 1'b1;
        ts  = burst ? 2'b00 : code;
        bad = !burst && (code == 2'b11 || lo + n > 4);
        if (ext && cal) bad = 1;

        @(negedge clk);
        s0 = cyc + 1;
        req_valid = 1; req_addr = addr; req_write = wr; req_size = size;
        req_burst = burst; req_bank = 2'(bank); req_cal = cal; req_ext = ext;
        ext_size_pins = pins; cfg_size_en = cen; cfg_size = csz;

        if (bad) begin
            push(s0, req, pack(0, 1, 0, 0, 0, 0, 32'h0, 2'b00, 4'h0));
            push(s0 + 1, req, idle_v());
            @(negedge clk);
            req_valid = 0;
            @(negedge clk);
            return;
        end

        for (int k = 0; k <= d; k++)
            push(s0 + k, req, pack(1, 0, cal, k == 0, wr, bank, addr, ts, be));
        push(s0 + d + 1, req, idle_v());

        @(negedge clk);
        req_valid = 0;
        if (spur) begin
            req_valid = 1;
            req_addr  = ~addr;
            req_bank  = 2'(bank ^ 1);
            req_cal   = ~cal;
            req_write = ~wr;
        end
        if (d == 0) xfer_ack = 1;
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            req_valid = 0;
            if (k == d) xfer_ack = 1;
        end
        @(negedge clk);
        xfer_ack = 0;
        req_valid = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        // R12: negated outputs during reset
        @(negedge clk);
        push(cyc, "R12 in reset", idle_v());
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        push(cyc, "R12 after reset", idle_v());

        // R1 R5 R6 R8 R9: primary byte write at offset 1, bank 2
        xfer(32'h1000_0001, 1, 2'b01, 0, 2, 0, 0, 2'b00, 0, 2'b00, 1, 0, "R1 R5 R6 R8 R9 byte write");
        // R1 R9: half-word read at offset 2, no data enable
        xfer(32'h2000_0002, 0, 2'b10, 0, 1, 0, 0, 2'b00, 0, 2'b00, 0, 0, "R1 R9 half read");
        // R1 R6: word write, long acknowledge wait
        xfer(32'h3000_0000, 1, 2'b00, 0, 0, 0, 0, 2'b00, 0, 2'b00, 3, 0, "R1 R6 word write");
        // R2: burst ignores requested byte size
        xfer(32'h4000_0003, 0, 2'b01, 1, 3, 0, 0, 2'b00, 0, 2'b00, 1, 0, "R2 burst");
        // R3: invalid size code
        xfer(32'h5000_0000, 1, 2'b11, 0, 0, 0, 0, 2'b00, 0, 2'b00, 0, 0, "R3 invalid code");
        // R3: half-word crossing the word boundary
        xfer(32'h5000_0003, 1, 2'b10, 0, 0, 0, 0, 2'b00, 0, 2'b00, 0, 0, "R3 half crossing");
        // R3: word at offset 2
        xfer(32'h5000_0002, 0, 2'b00, 0, 1, 1, 0, 2'b00, 0, 2'b00, 0, 0, "R3 word crossing");
        // R7 R5 R6 R9: calibration write, bank 3
        xfer(32'h6000_0000, 1, 2'b00, 0, 3, 1, 0, 2'b00, 0, 2'b00, 2, 0, "R7 cal write");
        // R7: calibration byte read
        xfer(32'h6100_0002, 0, 2'b01, 0, 0, 1, 0, 2'b00, 0, 2'b00, 0, 0, "R7 cal read");
        // R4: external master, override byte, pins say half
        xfer(32'h7000_0003, 1, 2'b00, 0, 1, 0, 1, 2'b10, 1, 2'b01, 0, 0, "R4 override used");
        // R4: external master, pins used when override off
        xfer(32'h7000_0000, 0, 2'b00, 0, 2, 0, 1, 2'b10, 0, 2'b01, 1, 0, "R4 pins used");
        // R4: self-mastered ignores an invalid override
        xfer(32'h7100_0000, 1, 2'b00, 0, 0, 0, 0, 2'b01, 1, 2'b11, 0, 0, "R4 own size kept");
        // R4 R3: external pins invalid, override off
        xfer(32'h7200_0000, 1, 2'b00, 0, 0, 0, 1, 2'b11, 0, 2'b00, 0, 0, "R4 R3 bad pins");
        // R10: external master aimed at calibration bus
        xfer(32'h8000_0000, 1, 2'b00, 0, 2, 1, 1, 2'b00, 0, 2'b00, 0, 0, "R10 ext to cal");
        // R11: extra request while busy is ignored
        xfer(32'h9000_0000, 1, 2'b00, 0, 1, 0, 0, 2'b00, 0, 2'b00, 2, 1, "R11 busy ignore");
        xfer(32'h9100_0001, 0, 2'b01, 0, 2, 1, 0, 2'b00, 0, 2'b00, 0, 1, "R11 busy ignore ack0");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", q.size());
        end
        summary();
        $finish;
    end

endmodule